// File: doc/BRIEF.md
# SDRAM Read Front End with Prefetch Window

This block sits in front of an SDRAM command sequencer and turns single-word read and write requests into SDRAM command sequences. When a read misses, the block opens the row, reads the demanded word, and then keeps reading the next WIN words into a small register window. It then closes the row. A later read that lands inside that window is answered from the registers one cycle after acceptance, and no SDRAM command is issued for it. A write to any word held in the window discards the whole window.

An internal timer raises a refresh request at an interval set on a control pin. A pending refresh blocks new requests. As soon as the sequencer is idle it precharges and refreshes, and then it holds requests off for a fixed recovery time. If the refresh request arrives while a miss is being served, the miss finishes first and the window it was filling is left unusable.

Requests use valid/ready. The requester holds `req_valid` and every request field steady until a cycle in which `req_ready` is high, and the request is taken at the end of that cycle. Responses are a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must always be able to take them. At most one read is outstanding, because `req_ready` stays low until a miss has fully finished.

Top module: `pfb_sdram_front`

## Requirements
- R1: A read miss at word address A produces these SDRAM commands in consecutive cycles: ACT (`sd_cmd`=1, `sd_addr`=A) in the cycle after acceptance, then WIN+1 READs (`sd_cmd`=2) at addresses A, A+1, …, A+WIN. PRECHARGE (`sd_cmd`=4) follows once all read data has returned. `rsp_valid` pulses with the word at A and `rsp_hit`=0, 3+CL cycles after the acceptance edge.
- R2: After a miss at A completes with no refresh pending, a read at any address in A+1..A+WIN is answered with `rsp_valid`=1, `rsp_hit`=1 and the stored word in the cycle after acceptance, and no SDRAM command is issued.
- R3: A read outside the current window, including the previous miss address A itself and A+WIN+1, is handled as a miss and rebuilds the window from its own address plus one.
- R4: A write produces ACT (`sd_addr`=address), then WR (`sd_cmd`=3, `sd_addr`=address, `sd_wdata`=data), then PRECHARGE in the three cycles after acceptance. It produces no response.
- R5: A write whose address lies inside a valid window invalidates the window, so a following read of that address is a miss that returns the new data. A write outside the window leaves it usable.
- R6: With `cfg_ref_interval`=N>0, a refresh request is raised every N cycles, and in an otherwise idle block REF commands are N cycles apart. With N=0 no refresh is ever issued.
- R7: While a refresh is pending, `req_ready` is low. From idle the block issues PRECHARGE and, in the next cycle, REF (`sd_cmd`=5). `req_ready` then stays low for REF_CYCLES cycles counted from the REF cycle.
- R8: A refresh request raised during a read miss does not disturb it. The demanded word is still returned on time, the refresh follows, and the window filled by that miss is invalid, so the next read in its range is a miss.
- R9: After reset, `req_ready`=1, `sd_cmd`=NOP (0) and `rsp_valid`=0. `req_ready` is low in the cycle after a miss or a write is accepted, and high after a hit.
- R10: A request presented while `req_ready` is low is not lost. It is taken once ready returns and is served with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ref_interval | input | RIW | Refresh interval in cycles, 0 disables |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | DW | Read data |
| rsp_hit | output | 1 | Response came from the window |
| sd_cmd | output | 3 | 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REF |
| sd_addr | output | AW | Command word address |
| sd_wdata | output | DW | Write data with WRITE |
| sd_rdata | input | DW | Read data, CL cycles after READ |

## Verification
The hardest case to reach from the ports is a refresh request that becomes pending in the middle of a miss. It never appears while a request is waiting, because a pending refresh already blocks acceptance. The bench reaches it by holding the interval at zero, which keeps the timer cleared. In the same cycle that it presents a miss, it loads a short interval, and it sets the interval back to zero after the timer fires. The request therefore lands inside the prefetch burst. Random traffic biased toward nearby addresses then exercises hits, window edges and invalidating writes, both with refresh disabled and with it running.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [2:0] {
    SD_NOP = 3'd0,
    SD_ACT = 3'd1,
    SD_RD  = 3'd2,
    SD_WR  = 3'd3,
    SD_PRE = 3'd4,
    SD_REF = 3'd5
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,
    ST_RD,
    ST_DRAIN,
    ST_WR,
    ST_PRE,
    ST_RFPRE,
    ST_RFREF,
    ST_RFWAIT
  } fe_state_e;
endpackage

// File: rtl/pfb_refresh_timer.sv
module pfb_refresh_timer #(
  parameter int RIW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RIW-1:0] interval,
  input  logic           ref_done,
  output logic           ref_pend
);
  logic [RIW-1:0] tick;
  logic           fire;

  assign fire = (interval != '0) && (tick >= interval - RIW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick     <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (interval == '0 || fire) tick <= '0;
      else                        tick <= tick + RIW'(1);
      if (fire)          ref_pend <= 1'b1;
      else if (ref_done) ref_pend <= 1'b0;
    end
  end

  // R6: a raised request stays until a refresh is issued
  p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend && !ref_done |=> ref_pend);
  // R7: REF is only issued against a pending request
  p_ref_when_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> ref_pend);
endmodule

// File: rtl/pfb_rd_track.sv
module pfb_rd_track #(
  parameter int CL = 2,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [IW-1:0] issue_idx,
  output logic          cap_valid,
  output logic [IW-1:0] cap_idx,
  output logic          busy
);
  logic [CL-1:0] v;
  logic [IW-1:0] ix [CL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0;
      for (int i = 0; i < CL; i++) ix[i] <= '0;
    end else begin
      v[0]  <= issue;
      ix[0] <= issue_idx;
      for (int i = 1; i < CL; i++) begin
        v[i]  <= v[i-1];
        ix[i] <= ix[i-1];
      end
    end
  end

  assign cap_valid = v[CL-1];
  assign cap_idx   = ix[CL-1];
  assign busy      = |v;

  // R1: an issued READ keeps the drain phase open
  p_issue_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> busy);
endmodule

// File: rtl/pfb_window.sv
module pfb_window #(
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int WIN = 4,
  parameter int IW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] look_data,
  input  logic          set_base,
  input  logic [AW-1:0] base_in,
  input  logic          inval,
  input  logic          mark_valid,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [DW-1:0] fill_data
);
  localparam int SW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          valid;
  logic [AW-1:0] base;
  logic [AW-1:0] diff;
  logic [DW-1:0] slot [WIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      base  <= '0;
    end else begin
      if (set_base) base <= base_in;
      if (set_base || inval) valid <= 1'b0;
      else if (mark_valid)   valid <= 1'b1;
    end
  end

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[g] <= '0;
      else if (fill_en && fill_idx == IW'(g + 1)) slot[g] <= fill_data;
    end
  end

  assign diff      = look_addr - base;
  assign hit       = valid && (diff < AW'(WIN));
  assign look_data = slot[diff[SW-1:0]];

  // R2: a window being filled is never offered as valid
  p_fill_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !valid);
  // R5: an invalidating write leaves the window unusable next cycle
  p_inval_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !hit);
endmodule

// File: rtl/pfb_sdram_front.sv
module pfb_sdram_front
  import pfb_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int WIN        = 4,
  parameter int CL         = 2,
  parameter int REF_CYCLES = 12,
  parameter int RIW        = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RIW-1:0] cfg_ref_interval,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_hit,
  output logic [2:0]     sd_cmd,
  output logic [AW-1:0]  sd_addr,
  output logic [DW-1:0]  sd_wdata,
  input  logic [DW-1:0]  sd_rdata
);
  localparam int IW  = $clog2(WIN + 1);
  localparam int RCW = (REF_CYCLES > 2) ? $clog2(REF_CYCLES) : 1;

  fe_state_e     state;
  logic [IW-1:0] cnt;
  logic [RCW-1:0] rw;
  logic          op_wr;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  sd_cmd_e       cmd;

  logic          ref_pend, ref_done;
  logic          acc, win_hit;
  logic [DW-1:0] win_data;
  logic          cap_valid, busy;
  logic [IW-1:0] cap_idx;

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign acc       = req_valid && req_ready;
  assign ref_done  = (state == ST_RFREF);

  pfb_refresh_timer #(.RIW(RIW)) u_timer (
    .clk(clk), .rst_n(rst_n), .interval(cfg_ref_interval),
    .ref_done(ref_done), .ref_pend(ref_pend)
  );

  pfb_rd_track #(.CL(CL), .IW(IW)) u_track (
    .clk(clk), .rst_n(rst_n), .issue(state == ST_RD), .issue_idx(cnt),
    .cap_valid(cap_valid), .cap_idx(cap_idx), .busy(busy)
  );

  pfb_window #(.AW(AW), .DW(DW), .WIN(WIN), .IW(IW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .look_addr(req_addr), .hit(win_hit), .look_data(win_data),
    .set_base(acc && !req_write && !win_hit), .base_in(req_addr + AW'(1)),
    .inval(acc && req_write && win_hit),
    .mark_valid(state == ST_PRE && !op_wr && !ref_pend),
    .fill_en(cap_valid && cap_idx != '0), .fill_idx(cap_idx), .fill_data(sd_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rw        <= '0;
      op_wr     <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (cap_valid && cap_idx == '0) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= sd_rdata;
        rsp_hit   <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (ref_pend) state <= ST_RFPRE;
          else if (acc) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            op_wr     <= req_write;
            if (!req_write && win_hit) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= win_data;
              rsp_hit   <= 1'b1;
            end else begin
              state <= ST_ACT;
            end
          end
        end
        ST_ACT: begin
          cnt   <= '0;
          state <= op_wr ? ST_WR : ST_RD;
        end
        ST_RD: begin
          if (cnt == IW'(WIN)) state <= ST_DRAIN;
          else                 cnt   <= cnt + IW'(1);
        end
        ST_DRAIN:  if (!busy) state <= ST_PRE;
        ST_WR:     state <= ST_PRE;
        ST_PRE:    state <= ST_IDLE;
        ST_RFPRE:  state <= ST_RFREF;
        ST_RFREF: begin
          rw    <= '0;
          state <= (REF_CYCLES > 1) ? ST_RFWAIT : ST_IDLE;
        end
        ST_RFWAIT: begin
          if (rw >= RCW'(REF_CYCLES - 2)) state <= ST_IDLE;
          else                            rw    <= rw + RCW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd      = SD_NOP;
    sd_addr  = '0;
    sd_wdata = '0;
    unique case (state)
      ST_ACT:   begin cmd = SD_ACT; sd_addr = lat_addr; end
      ST_RD:    begin cmd = SD_RD;  sd_addr = lat_addr + AW'(cnt); end
      ST_WR:    begin cmd = SD_WR;  sd_addr = lat_addr; sd_wdata = lat_wdata; end
      ST_PRE,
      ST_RFPRE: cmd = SD_PRE;
      ST_RFREF: cmd = SD_REF;
      default:  cmd = SD_NOP;
    endcase
  end
  assign sd_cmd = cmd;

  // R1, R4: a miss or a write opens a row in the next cycle
  p_act_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_write || !win_hit) |=> sd_cmd == SD_ACT);
  // R2: a hit answers next cycle from the window
  p_hit_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && win_hit |=> rsp_valid && rsp_hit);
  // R7: pending refresh blocks acceptance
  p_pend_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);
  // R7: REF is preceded by PRECHARGE
  p_pre_before_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd == SD_REF |-> $past(sd_cmd) == SD_PRE);
  // R7: recovery keeps requests off after REF
  p_ref_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cmd == SD_REF |=> !req_ready);
endmodule

// File: tb/tb_pfb_sdram_front.sv
module tb_pfb_sdram_front;
  localparam int AW = 24, DW = 32, WIN = 4, CL = 2, RC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cfg_ref_interval = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_rdata, sd_wdata, sd_rdata;
  logic [2:0]    sd_cmd;
  logic [AW-1:0] sd_addr;

  always #5 clk = ~clk;

  pfb_sdram_front #(.AW(AW), .DW(DW), .WIN(WIN), .CL(CL), .REF_CYCLES(RC), .RIW(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ref_interval(cfg_ref_interval),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit),
    .sd_cmd(sd_cmd), .sd_addr(sd_addr), .sd_wdata(sd_wdata), .sd_rdata(sd_rdata)
  );

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  // simplified SDRAM model
  logic [31:0] mem [1024];
  bit          wrote [1024];
  logic        pv [CL];
  logic [9:0]  pa [CL];
  always @(posedge clk) begin
    if (sd_cmd == 3'd3) begin mem[sd_addr[9:0]] <= sd_wdata; wrote[sd_addr[9:0]] <= 1'b1; end
    pv[0] <= (sd_cmd == 3'd2);
    pa[0] <= sd_addr[9:0];
    for (int i = 1; i < CL; i++) begin pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; end
  end
  assign sd_rdata = wrote[pa[CL-1]] ? mem[pa[CL-1]] : init_word(int'(pa[CL-1]));

  // command monitor
  int          cyc = 0, nlog = 0, ref_cnt = 0, last_ref = 0;
  logic [2:0]  prev_cmd = 3'd0, ref_prev = 3'd0;
  logic [2:0]  cmd_log [4096];
  logic [23:0] addr_log [4096];
  logic [31:0] data_log [4096];
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && sd_cmd != 3'd0 && nlog < 4096) begin
      cmd_log[nlog] = sd_cmd; addr_log[nlog] = sd_addr; data_log[nlog] = sd_wdata;
      nlog = nlog + 1;
    end
    if (rst_n && sd_cmd == 3'd5) begin ref_cnt = ref_cnt + 1; last_ref = cyc; ref_prev = prev_cmd; end
    prev_cmd = sd_cmd;
  end

  int n_chk = 0, n_fail = 0;
  logic [31:0] refm [1024];
  bit          wd = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!req_ready && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic issue(input bit wr, input logic [23:0] a, input logic [31:0] d, output int waited);
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready && waited < 2000) begin @(negedge clk); waited++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [23:0] a, output logic [31:0] data, output bit hit,
                         output int lat, output int waited);
    issue(1'b0, a, '0, waited);
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    data = rsp_rdata; hit = rsp_hit;
    wait_idle();
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d);
    int w;
    issue(1'b1, a, d, w);
    refm[a[9:0]] = d;
    wait_idle();
  endtask

  task automatic run_all();
    logic [31:0] d; bit h; int lat, w, base, t1, r0;
    logic [23:0] win_base, a, last;
    bit win_v, exp_hit;

    for (int i = 0; i < 1024; i++) refm[i] = init_word(i);
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 reset ready", {31'd0, req_ready}, 1);
    chk(sd_cmd == 3'd0, "R9 reset cmd", {29'd0, sd_cmd}, 0);
    chk(rsp_valid == 1'b0, "R9 reset rsp", {31'd0, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 miss sequence
    base = nlog;
    issue(1'b0, 24'd100, '0, w);
    chk(req_ready == 1'b0, "R9 busy after miss", {31'd0, req_ready}, 0);
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == 3 + CL, "R1 miss latency", lat, 3 + CL);
    chk(rsp_rdata == init_word(100), "R1 miss data", rsp_rdata, init_word(100));
    chk(rsp_hit == 1'b0, "R1 miss flag", {31'd0, rsp_hit}, 0);
    wait_idle();
    chk(nlog - base == WIN + 3, "R1 command count", nlog - base, WIN + 3);
    chk(cmd_log[base] == 3'd1 && addr_log[base] == 24'd100, "R1 ACT", {29'd0, cmd_log[base]}, 1);
    for (int k = 0; k <= WIN; k++)
      chk(cmd_log[base+1+k] == 3'd2 && addr_log[base+1+k] == 24'(100 + k), "R1 READ addr",
          {8'd0, addr_log[base+1+k]}, 100 + k);
    chk(cmd_log[base+WIN+2] == 3'd4, "R1 PRE", {29'd0, cmd_log[base+WIN+2]}, 4);

    // R2 hits at both ends of the window, no commands
    base = nlog;
    issue(1'b0, 24'd101, '0, w);
    chk(rsp_valid && rsp_hit, "R2 hit next cycle", {30'd0, rsp_valid, rsp_hit}, 3);
    chk(rsp_rdata == init_word(101), "R2 hit data", rsp_rdata, init_word(101));
    chk(req_ready == 1'b1, "R9 ready after hit", {31'd0, req_ready}, 1);
    do_read(24'd104, d, h, lat, w);
    chk(h && lat == 1 && d == init_word(104), "R2 hit upper edge", d, init_word(104));
    chk(nlog == base, "R2 no SDRAM command on hit", nlog - base, 0);

    // R3 just above window, then the old miss address itself
    do_read(24'd105, d, h, lat, w);
    chk(!h && lat == 3 + CL && d == init_word(105), "R3 above window miss", {31'd0, h}, 0);
    do_read(24'd105, d, h, lat, w);
    chk(!h && d == init_word(105), "R3 own address miss", {31'd0, h}, 0);
    do_read(24'd106, d, h, lat, w);
    chk(h && d == init_word(106), "R3 rebuilt window", {31'd0, h}, 1);

    // R4 write sequence, outside window
    base = nlog;
    do_write(24'd200, 32'hCAFE_0001);
    chk(nlog - base == 3, "R4 write command count", nlog - base, 3);
    chk(cmd_log[base] == 3'd1 && addr_log[base] == 24'd200, "R4 ACT", {29'd0, cmd_log[base]}, 1);
    chk(cmd_log[base+1] == 3'd3 && addr_log[base+1] == 24'd200 && data_log[base+1] == 32'hCAFE_0001,
        "R4 WR", data_log[base+1], 32'hCAFE_0001);
    chk(cmd_log[base+2] == 3'd4, "R4 PRE", {29'd0, cmd_log[base+2]}, 4);
    // R5 outside write keeps window, inside write invalidates
    do_read(24'd107, d, h, lat, w);
    chk(h && d == init_word(107), "R5 window kept", {31'd0, h}, 1);
    do_write(24'd108, 32'hBEEF_0108);
    do_read(24'd108, d, h, lat, w);
    chk(!h && d == 32'hBEEF_0108, "R5 invalidated read new data", d, 32'hBEEF_0108);

    // R6 / R7 refresh cadence and recovery
    cfg_ref_interval = 16'd40;
    r0 = ref_cnt; w = 0;
    while (ref_cnt == r0 && w < 500) begin @(negedge clk); w++; end
    chk(ref_prev == 3'd4, "R7 PRE before REF", {29'd0, ref_prev}, 4);
    lat = 0;
    while (!req_ready && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == RC - 1, "R7 recovery length", lat, RC - 1);
    t1 = last_ref; r0 = ref_cnt; w = 0;
    while (ref_cnt == r0 && w < 500) begin @(negedge clk); w++; end
    chk(last_ref - t1 == 40, "R6 refresh period", last_ref - t1, 40);
    cfg_ref_interval = 16'd0;
    wait_idle();
    r0 = ref_cnt;
    repeat (200) @(negedge clk);
    chk(ref_cnt == r0, "R6 disabled", ref_cnt - r0, 0);

    // R10 request held across a refresh
    cfg_ref_interval = 16'd3;
    w = 0;
    while (req_ready && w < 50) begin @(negedge clk); w++; end
    cfg_ref_interval = 16'd0;
    do_read(24'd150, d, h, lat, w);
    chk(w >= RC - 1, "R10 held while not ready", w, RC - 1);
    chk(d == init_word(150), "R10 held request data", d, init_word(150));

    // R8 refresh raised during a miss
    wait_idle();
    r0 = ref_cnt;
    @(negedge clk);
    cfg_ref_interval = 16'd4;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'd60;
    chk(req_ready == 1'b1, "R8 setup ready", {31'd0, req_ready}, 1);
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    cfg_ref_interval = 16'd0;
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == init_word(60), "R8 miss completes", rsp_rdata, init_word(60));
    wait_idle();
    chk(ref_cnt == r0 + 1, "R8 refresh followed", ref_cnt - r0, 1);
    do_read(24'd61, d, h, lat, w);
    chk(!h && d == init_word(61), "R8 window left invalid", {31'd0, h}, 0);

    // random phase, refresh off: full model
    win_v = 1'b0; win_base = '0; last = 24'd10;
    do_read(24'd10, d, h, lat, w);
    win_v = 1'b1; win_base = 24'd11;
    for (int n = 0; n < 300; n++) begin
      a = ($urandom % 3 == 0) ? 24'($urandom % 256) : 24'((int'(last) + $urandom % 7) % 256);
      if ($urandom % 4 == 0) begin
        if (win_v && (a - win_base) < 24'(WIN)) win_v = 1'b0;
        do_write(a, $urandom);
      end else begin
        exp_hit = win_v && (a - win_base) < 24'(WIN);
        do_read(a, d, h, lat, w);
        chk(d == refm[a[9:0]], "R2 R3 random data", d, refm[a[9:0]]);
        chk(h == exp_hit, "R2 R3 random hit flag", {31'd0, h}, {31'd0, exp_hit});
        chk(lat == (exp_hit ? 1 : 3 + CL), "R1 R2 random latency", lat, exp_hit ? 1 : 3 + CL);
        if (!exp_hit) begin win_v = 1'b1; win_base = a + 24'd1; end
      end
      last = a;
    end

    // random phase, refresh on: data only
    cfg_ref_interval = 16'd30;
    for (int n = 0; n < 200; n++) begin
      a = ($urandom % 3 == 0) ? 24'($urandom % 256) : 24'((int'(last) + $urandom % 7) % 256);
      if ($urandom % 4 == 0) do_write(a, $urandom);
      else begin
        do_read(a, d, h, lat, w);
        chk(d == refm[a[9:0]], "R10 R8 data under refresh", d, refm[a[9:0]]);
      end
      last = a;
    end
    cfg_ref_interval = 16'd0;
  endtask

  initial begin
    fork
      run_all();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    if (wd) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule